// File: doc/BRIEF.md
# Masked burst address counter

This block generates the address for one port of a synchronous dual-port memory. A loadable counter walks through bursts of addresses. A mask register marks which low-order bits are allowed to count. A mirror register keeps the most recently loaded start address. When the counting field reaches its top value, the next increment returns the field to the start address, so the same burst repeats for as long as counting stays on.

A load with the counter/mask select high writes the external address into the counter and into the mirror. A load with the select low writes the mask register instead. A mask whose bit 0 is clear makes the counter step by two. This lets two ports share one address space, one port walking the even locations and the other the odd ones.

A counter reset clears only the counting field and costs no extra cycle. A readback request returns either the counter or the mask value. An active-low wrap flag marks the moment the counting field reaches its maximum.

Top module: `burst_addr_gen`

## Requirements
- R1: A cycle with `rst` high sets the counter, the mirror and the readback value to zero, sets the mask to all ones and drives `wrap_n` high, all visible on the following cycle; `rst` overrides every other input.
- R2: A load (`load_en` high, `ctr_sel` high, no `ctr_clr`) places `ext_addr` on `int_addr` the next cycle, stores it as the burst start and drives `wrap_n` high.
- R3: A load with `ctr_sel` low writes `ext_addr` into the mask and leaves `int_addr` unchanged.
- R4: With `count_en` high and mask bit 0 set, the bits under mask ones increase by one each cycle and the bits under mask zeros keep their value.
- R5: With mask bit 0 clear, each increment adds two to the counting field and bit 0 of `int_addr` keeps its value.
- R6: An increment while the counting field equals the mask (its maximum) loads the counting field from the stored burst start, so the burst repeats.
- R7: `wrap_n` goes low on the cycle after an increment that brings the counting field to its maximum. It goes high after the following wrap reload, and after any load, counter reset or master reset. Hold and readback cycles leave it unchanged.
- R8: A counter reset (`ctr_clr` high) clears the bits under mask ones, keeps the bits under mask zeros, and drives `wrap_n` high on the next cycle. It takes priority over load, readback and increment.
- R9: A readback request (`rdbk_req` high, no reset or load) sets `rdbk_val` the next cycle: to the counter value when `ctr_sel` is high, or to the mask when it is low. The counter does not advance in that cycle. At other times `rdbk_val` holds its value.
- R10: With no reset, load, readback or `count_en`, `int_addr` and `wrap_n` hold their values.
- R11: The priority order is master reset, then counter reset, then load, then readback, then increment, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Master reset, synchronous, active high |
| ext_addr | input | AW | External address, or the mask value for a mask load |
| load_en | input | 1 | Load strobe |
| count_en | input | 1 | Increment enable |
| ctr_clr | input | 1 | Clears the counting field of the counter |
| ctr_sel | input | 1 | 1 selects the counter, 0 selects the mask, for load and readback |
| rdbk_req | input | 1 | Readback request |
| int_addr | output | AW | Counter value driven to the address decode |
| rdbk_val | output | AW | Value captured by the last readback |
| wrap_n | output | 1 | Low when the counting field has reached its maximum |

## Verification
Every result comes out of a register, so the effect of a command applied before a rising edge shows on `int_addr`, `rdbk_val` and `wrap_n` right after that edge, one cycle later, and no path has more delay than that. The bench drives inputs at the falling edge and advances its reference model by one command. At the next falling edge it compares all three outputs with the model, so each command is checked in exactly the cycle its effect is due. Wrap reloads, step-by-two bursts, clears against loads and resets in the middle of a burst are each lined up on that same one-cycle grid.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD     = 3'd0,
        CMD_CLR      = 3'd1,
        CMD_LOAD_CNT = 3'd2,
        CMD_LOAD_MSK = 3'd3,
        CMD_RDBK_CNT = 3'd4,
        CMD_RDBK_MSK = 3'd5,
        CMD_INC      = 3'd6
    } burst_cmd_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic rdbk;
        logic inc;
        logic sel_ctr;
    } burst_ctrl_t;

    // Priority: counter reset, load, readback, increment, hold.
    // The master reset is applied directly inside every register stage.
    function automatic burst_cmd_e decode_cmd(input burst_ctrl_t c);
        if (c.clr)
            return CMD_CLR;
        else if (c.load)
            return c.sel_ctr ? CMD_LOAD_CNT : CMD_LOAD_MSK;
        else if (c.rdbk)
            return c.sel_ctr ? CMD_RDBK_CNT : CMD_RDBK_MSK;
        else if (c.inc)
            return CMD_INC;
        else
            return CMD_HOLD;
    endfunction

endpackage

// File: rtl/burst_mask_reg.sv
module burst_mask_reg
    import burst_ctr_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  burst_cmd_e    cmd,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (cmd == CMD_LOAD_MSK)
            mask_q <= ext_addr;
    end

endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_ctr_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  burst_cmd_e    cmd,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] cnt_q,
    output logic          wrap_n
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    logic [AW-1:0] mirror_q;
    logic [AW-1:0] field;
    logic [AW-1:0] fixed_bits;
    logic [AW-1:0] step;
    logic [AW-1:0] bumped;
    logic          at_max;
    logic          lands_max;

    always_comb begin
        field      = cnt_q & mask;
        fixed_bits = cnt_q & ~mask;
        step       = mask[0] ? STEP_ONE : STEP_TWO;
        bumped     = (field + step) & mask;
        at_max     = (field == mask);
        lands_max  = (bumped == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            mirror_q <= '0;
            wrap_n   <= 1'b1;
        end else begin
            unique case (cmd)
                CMD_CLR: begin
                    cnt_q  <= fixed_bits;
                    wrap_n <= 1'b1;
                end
                CMD_LOAD_CNT: begin
                    cnt_q    <= ext_addr;
                    mirror_q <= ext_addr;
                    wrap_n   <= 1'b1;
                end
                CMD_LOAD_MSK: begin
                    wrap_n <= 1'b1;
                end
                CMD_INC: begin
                    if (at_max) begin
                        cnt_q  <= fixed_bits | (mirror_q & mask);
                        wrap_n <= 1'b1;
                    end else begin
                        cnt_q  <= fixed_bits | bumped;
                        wrap_n <= ~lands_max;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_readback.sv
module burst_readback
    import burst_ctr_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  burst_cmd_e    cmd,
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] rdbk_q
);

    always_ff @(posedge clk) begin
        if (rst)
            rdbk_q <= '0;
        else if (cmd == CMD_RDBK_CNT)
            rdbk_q <= cnt;
        else if (cmd == CMD_RDBK_MSK)
            rdbk_q <= mask;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_ctr_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          load_en,
    input  logic          count_en,
    input  logic          ctr_clr,
    input  logic          ctr_sel,
    input  logic          rdbk_req,
    output logic [AW-1:0] int_addr,
    output logic [AW-1:0] rdbk_val,
    output logic          wrap_n
);

    burst_ctrl_t   ctrl;
    burst_cmd_e    cmd;
    logic [AW-1:0] mask_q;

    always_comb begin
        ctrl.clr     = ctr_clr;
        ctrl.load    = load_en;
        ctrl.rdbk    = rdbk_req;
        ctrl.inc     = count_en;
        ctrl.sel_ctr = ctr_sel;
        cmd          = decode_cmd(ctrl);
    end

    burst_mask_reg #(.AW(AW)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .mask_q   (mask_q)
    );

    burst_counter #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .mask     (mask_q),
        .cnt_q    (int_addr),
        .wrap_n   (wrap_n)
    );

    burst_readback #(.AW(AW)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cnt      (int_addr),
        .mask     (mask_q),
        .rdbk_q   (rdbk_val)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          load_en,
    input logic          count_en,
    input logic          ctr_clr,
    input logic          ctr_sel,
    input logic          rdbk_req,
    input logic [AW-1:0] int_addr,
    input logic [AW-1:0] rdbk_val,
    input logic          wrap_n,
    input logic [AW-1:0] mask_q
);

    // R1
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (int_addr == '0) && (rdbk_val == '0) && wrap_n && (mask_q == '1));

    // R2
    assert_load_counter_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clr && load_en && ctr_sel) |=> (int_addr == $past(ext_addr)) && wrap_n);

    // R3
    assert_mask_load_keeps_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clr && load_en && !ctr_sel) |=> $stable(int_addr));

    // R4 / R5: increment never disturbs bits outside the counting field
    assert_inc_keeps_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clr && !load_en && !rdbk_req && count_en)
        |=> ((int_addr & ~mask_q) == ($past(int_addr) & ~mask_q)));

    // R7
    assert_wrap_from_inc_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wrap_n) |-> $past(count_en && !ctr_clr && !load_en && !rdbk_req));

    // R8
    assert_clear_field_R8: assert property (@(posedge clk) disable iff (rst)
        ctr_clr |=> ((int_addr & $past(mask_q)) == '0)
                 && ((int_addr & ~$past(mask_q)) == ($past(int_addr) & ~$past(mask_q)))
                 && wrap_n);

    // R9
    assert_readback_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clr && !load_en && rdbk_req) |=> $stable(int_addr) && $stable(wrap_n));

    // R10
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctr_clr && !load_en && !rdbk_req && !count_en)
        |=> $stable(int_addr) && $stable(wrap_n) && $stable(rdbk_val));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .load_en  (load_en),
    .count_en (count_en),
    .ctr_clr  (ctr_clr),
    .ctr_sel  (ctr_sel),
    .rdbk_req (rdbk_req),
    .int_addr (int_addr),
    .rdbk_val (rdbk_val),
    .wrap_n   (wrap_n),
    .mask_q   (mask_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int AW = 17;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ext_addr;
    logic          load_en, count_en, ctr_clr, ctr_sel, rdbk_req;
    logic [AW-1:0] int_addr, rdbk_val;
    logic          wrap_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state
    logic [AW-1:0] m_cnt, m_mask, m_mir, m_rb;
    logic          m_wn;

    always #4 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .load_en(load_en),
        .count_en(count_en), .ctr_clr(ctr_clr), .ctr_sel(ctr_sel),
        .rdbk_req(rdbk_req), .int_addr(int_addr), .rdbk_val(rdbk_val),
        .wrap_n(wrap_n)
    );

    // behavioural next-state of the reference, straight from the requirements
    task automatic model_step();
        logic [AW-1:0] fld, nxt;
        int stp;
        if (rst) begin
            m_cnt = '0; m_mask = '1; m_mir = '0; m_rb = '0; m_wn = 1'b1;
        end else if (ctr_clr) begin
            m_cnt = m_cnt & ~m_mask; m_wn = 1'b1;
        end else if (load_en) begin
            if (ctr_sel) begin m_cnt = ext_addr; m_mir = ext_addr; end
            else m_mask = ext_addr;
            m_wn = 1'b1;
        end else if (rdbk_req) begin
            m_rb = ctr_sel ? m_cnt : m_mask;
        end else if (count_en) begin
            fld = m_cnt & m_mask;
            stp = m_mask[0] ? 1 : 2;
            if (fld == m_mask) begin
                m_cnt = (m_cnt & ~m_mask) | (m_mir & m_mask);
                m_wn  = 1'b1;
            end else begin
                nxt   = (fld + AW'(stp)) & m_mask;
                m_cnt = (m_cnt & ~m_mask) | nxt;
                m_wn  = (nxt != m_mask);
            end
        end
    endtask

    // drive at the falling edge, compare at the next falling edge
    task automatic cyc(input string tag, input bit r, input logic [AW-1:0] a,
                       input bit ld, input bit ce, input bit clr, input bit sel,
                       input bit rb);
        rst = r; ext_addr = a; load_en = ld; count_en = ce;
        ctr_clr = clr; ctr_sel = sel; rdbk_req = rb;
        model_step();
        @(negedge clk);
        vectors++;
        if (int_addr !== m_cnt || rdbk_val !== m_rb || wrap_n !== m_wn) begin
            errors++;
            $display("FAIL %s: int_addr=%h rdbk_val=%h wrap_n=%b expected %h %h %b",
                     tag, int_addr, rdbk_val, wrap_n, m_cnt, m_rb, m_wn);
        end
    endtask

    function automatic logic [AW-1:0] contig_mask(input int len, input bit even);
        logic [AW-1:0] mk = '0;
        for (int i = 0; i < len; i++) mk[i] = 1'b1;
        if (even) mk[0] = 1'b0;
        return mk;
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_cnt = '0; m_mask = '1; m_mir = '0; m_rb = '0; m_wn = 1'b1;
        // R1: reset, then read back mask (all ones) and counter
        cyc("R1", 1, 17'h0ABCD, 1, 1, 0, 1, 0);
        cyc("R1", 1, 17'h0, 0, 0, 0, 0, 0);
        cyc("R1", 0, 17'h0, 0, 0, 0, 0, 1);
        cyc("R1", 0, 17'h0, 0, 0, 0, 1, 1);
        // R2 counter load, R3 mask load
        cyc("R2", 0, 17'h1FFF0, 1, 0, 0, 1, 0);
        cyc("R3", 0, 17'h0000F, 1, 1, 0, 0, 0);
        cyc("R3", 0, 17'h0, 0, 0, 0, 0, 1);
        // R4 R6 R7: run through the burst twice
        for (int i = 0; i < 34; i++) cyc("R4_R6_R7", 0, 17'h0, 0, 1, 0, 1, 0);
        // R10 hold
        for (int i = 0; i < 3; i++) cyc("R10", 0, 17'h15555, 0, 0, 0, 1, 0);
        // R9: readback of counter wins over increment
        cyc("R9", 0, 17'h0, 0, 1, 0, 1, 1);
        cyc("R9", 0, 17'h0, 0, 1, 0, 0, 1);
        // R8 R11: clear together with load and increment
        cyc("R8", 0, 17'h12345, 1, 1, 1, 1, 1);
        cyc("R8", 0, 17'h0, 0, 0, 0, 1, 1);
        // R5: step by two, mask 0x0000E, start 0x10005
        cyc("R5", 0, 17'h0000E, 1, 0, 0, 0, 0);
        cyc("R5", 0, 17'h10005, 1, 0, 0, 1, 0);
        for (int i = 0; i < 12; i++) cyc("R5_R6_R7", 0, 17'h0, 0, 1, 0, 1, 0);
        // R7: reach the maximum then hold; the flag stays low
        cyc("R7", 0, 17'h1000D, 1, 0, 0, 1, 0);
        cyc("R7", 0, 17'h0, 0, 1, 0, 1, 0);
        cyc("R7", 0, 17'h0, 0, 0, 0, 1, 0);
        cyc("R7", 0, 17'h0, 0, 0, 0, 1, 1);
        cyc("R8", 0, 17'h0, 0, 1, 1, 1, 0);
        // R11: master reset in the middle of a load
        cyc("R11", 1, 17'h1FFFF, 1, 1, 1, 1, 1);
        cyc("R11", 0, 17'h0, 0, 0, 0, 0, 1);
        // mixed traffic with contiguous masks
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            bit r, ld, ce, clr, sel, rb;
            r   = ($urandom_range(0, 99) == 0);
            ld  = ($urandom_range(0, 9) == 0);
            clr = ($urandom_range(0, 19) == 0);
            rb  = ($urandom_range(0, 7) == 0);
            ce  = ($urandom_range(0, 3) != 0);
            sel = ($urandom_range(0, 3) != 0);
            a   = AW'($urandom);
            if (ld && !sel) a = contig_mask($urandom_range(2, 6), $urandom_range(0, 1) == 1);
            cyc("R11_mix", r, a, ld, ce, clr, sel, rb);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule